// File: doc/BRIEF.md
# Parallel converter conversion sequencer

This block sits on the host side of a 12-bit parallel analogue-to-digital converter and drives its control lines. After reset it holds off for a power-up interval. It then turns each conversion request into a single active-low start pulse and waits for the converter's end-of-conversion line to go high. Next it performs the chip-select and output-enable read cycle and hands the reassembled 12-bit sample to the host as a one-cycle valid strobe with data.

The read can be a single 12-bit access. It can also be two byte accesses over the upper eight data lines, high byte first, with the byte layout chosen by a justification line that the sequencer drives to the converter. The sequencer enforces a minimum spacing between start pulses and a recovery gap after output enable rises. A request made too early is held rather than lost. A converter that never signals completion is detected by a timeout. Every interval is a parameter counted in clock cycles.

Top module: `adc_seq`

## Requirements
- R1: While reset is asserted, `adc_sc_n`, `adc_cs_n` and `adc_oe_n` are high, and `res_valid` and `eoc_timeout` are low. After reset is released, `adc_sc_n` stays high for at least POWERUP_CYC cycles.
- R2: Each start pulse holds `adc_sc_n` low for exactly one cycle. Two falling edges of `adc_sc_n` are at least MIN_INTERVAL_CYC cycles apart.
- R3: A one-cycle `conv_req` that arrives while a start is not yet allowed (during power-up, a conversion, recovery or the start spacing) is held and served later. Any number of requests that arrive while one is held are merged into a single conversion.
- R4: The read cycle starts only after `adc_eoc` is seen high. The converter must pull `adc_eoc` low by the cycle after the start pulse. `adc_cs_n` falls at least CS_SETUP_CYC cycles before `adc_oe_n` falls.
- R5: In wide mode (`wide_mode`=1 at the start), there is exactly one output-enable window of READ_CYC cycles with `adc_hi_byte`=1. `res_data` equals `adc_data[11:0]` as sampled in the last cycle of that window.
- R6: In narrow mode (`wide_mode`=0), there are two windows back to back: first with `adc_hi_byte`=1, then with 0. Only `adc_data[11:4]` is used. With right justification the high byte is {0000, d[11:8]} and the low byte is d[7:0]. With left justification the high byte is d[11:4] and the low byte is {d[3:0], 0000}. `res_data` is the rebuilt d.
- R7: `wide_mode` and `right_just` are sampled in the cycle the start is decided. `adc_right_just` shows the sampled justification. Changing either input afterwards has no effect on that conversion.
- R8: Each completed read gives exactly one `res_valid` pulse, one cycle wide, with `res_data` valid in the same cycle.
- R9: After `adc_oe_n` rises, at least RECOVER_CYC cycles pass before the next falling edge of `adc_sc_n`.
- R10: If `adc_eoc` does not go high within EOC_TIMEOUT_CYC cycles of the start pulse, `eoc_timeout` pulses for one cycle. In that case there is no read and no `res_valid`, and the sequencer accepts requests again.
- R11: `adc_oe_n` is low only while `adc_cs_n` is low. Neither of them is low while `adc_sc_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_req | input | 1 | Conversion request pulse |
| wide_mode | input | 1 | 1: single 12-bit read, 0: two byte reads |
| right_just | input | 1 | Byte layout for narrow reads, 1 = right justified |
| adc_eoc | input | 1 | Converter end of conversion, high = result ready |
| adc_data | input | 12 | Converter data lines |
| adc_sc_n | output | 1 | Start-convert pulse, active low |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_oe_n | output | 1 | Output enable, active low |
| adc_hi_byte | output | 1 | Byte select to converter, 1 = high byte |
| adc_right_just | output | 1 | Justification select to converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 12 | Reassembled result |
| eoc_timeout | output | 1 | One-cycle pulse when the converter does not answer |

## Verification
The hardest situation to reach is a request that lands while a start is still forbidden. This case must be held and then merged with later requests, without ever breaking the start spacing or the recovery gap. The stimulus fires requests during power-up and again at once after each result. It also fires two requests inside one spacing window. A converter stub with random latency keeps the spacing, recovery and setup timing under watch on every conversion. The stub can also stay silent to force the timeout path. One directed run flips the mode inputs in the middle of a read.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int DATA_W           = 12,
  parameter int BYTE_W           = 8,
  parameter int POWERUP_CYC      = 500,
  parameter int MIN_INTERVAL_CYC = 250,
  parameter int CS_SETUP_CYC     = 3,
  parameter int READ_CYC         = 4,
  parameter int RECOVER_CYC      = 5,
  parameter int EOC_TIMEOUT_CYC  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_req,
  input  logic              wide_mode,
  input  logic              right_just,
  input  logic              adc_eoc,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_sc_n,
  output logic              adc_cs_n,
  output logic              adc_oe_n,
  output logic              adc_hi_byte,
  output logic              adc_right_just,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              eoc_timeout
);
  localparam int LO_W    = DATA_W - BYTE_W;
  localparam int MAX_A   = POWERUP_CYC > EOC_TIMEOUT_CYC ? POWERUP_CYC : EOC_TIMEOUT_CYC;
  localparam int MAX_B   = CS_SETUP_CYC > READ_CYC ? CS_SETUP_CYC : READ_CYC;
  localparam int MAX_C   = MAX_B > RECOVER_CYC ? MAX_B : RECOVER_CYC;
  localparam int CNT_MAX = MAX_A > MAX_C ? MAX_A : MAX_C;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int IV_W    = $clog2(MIN_INTERVAL_CYC + 1);

  typedef enum logic [2:0] {
    S_PWR, S_IDLE, S_START, S_WAIT, S_SETUP, S_RD_HI, S_RD_LO, S_RECOV
  } st_t;

  st_t              st, nxt;
  logic [CNT_W-1:0] cnt, dur_m1;
  logic [IV_W-1:0]  iv_cnt;
  logic             pend, wide_q, rj_q, last, iv_ok, go;
  logic [BYTE_W-1:0] hi_q;
  logic [BYTE_W-1:0] bus_byte;

  assign bus_byte = adc_data[DATA_W-1 -: BYTE_W];
  assign iv_ok    = iv_cnt >= IV_W'(MIN_INTERVAL_CYC - 1);
  assign go       = (st == S_IDLE) && (pend || conv_req) && iv_ok;
  assign last     = cnt == dur_m1;

  always_comb begin
    case (st)
      S_PWR:   dur_m1 = CNT_W'(POWERUP_CYC - 1);
      S_WAIT:  dur_m1 = CNT_W'(EOC_TIMEOUT_CYC - 1);
      S_SETUP: dur_m1 = CNT_W'(CS_SETUP_CYC - 1);
      S_RD_HI,
      S_RD_LO: dur_m1 = CNT_W'(READ_CYC - 1);
      S_RECOV: dur_m1 = CNT_W'(RECOVER_CYC - 1);
      default: dur_m1 = '0;
    endcase
  end

  always_comb begin
    nxt = st;
    case (st)
      S_PWR:   if (last) nxt = S_IDLE;
      S_IDLE:  if (go) nxt = S_START;
      S_START: nxt = S_WAIT;
      S_WAIT:  if (adc_eoc) nxt = S_SETUP;
               else if (last) nxt = S_IDLE;
      S_SETUP: if (last) nxt = S_RD_HI;
      S_RD_HI: if (last) nxt = wide_q ? S_RECOV : S_RD_LO;
      S_RD_LO: if (last) nxt = S_RECOV;
      S_RECOV: if (last) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_PWR;
      cnt    <= '0;
      iv_cnt <= IV_W'(MIN_INTERVAL_CYC);
      pend   <= 1'b0;
    end else begin
      st   <= nxt;
      cnt  <= (nxt != st) ? '0 : cnt + 1'b1;
      pend <= go ? 1'b0 : (pend | conv_req);
      if (st == S_START)
        iv_cnt <= IV_W'(1);
      else if (iv_cnt != IV_W'(MIN_INTERVAL_CYC))
        iv_cnt <= iv_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wide_q      <= 1'b1;
      rj_q        <= 1'b0;
      hi_q        <= '0;
      res_data    <= '0;
      res_valid   <= 1'b0;
      eoc_timeout <= 1'b0;
    end else begin
      res_valid   <= 1'b0;
      eoc_timeout <= (st == S_WAIT) && !adc_eoc && last;
      if (go) begin
        wide_q <= wide_mode;
        rj_q   <= right_just;
      end
      if (st == S_RD_HI && last) begin
        hi_q <= bus_byte;
        if (wide_q) begin
          res_data  <= adc_data;
          res_valid <= 1'b1;
        end
      end
      if (st == S_RD_LO && last) begin
        res_data  <= rj_q ? {hi_q[LO_W-1:0], bus_byte}
                          : {hi_q, bus_byte[BYTE_W-1 -: LO_W]};
        res_valid <= 1'b1;
      end
    end
  end

  assign adc_sc_n       = st != S_START;
  assign adc_cs_n       = !(st == S_SETUP || st == S_RD_HI || st == S_RD_LO);
  assign adc_oe_n       = !(st == S_RD_HI || st == S_RD_LO);
  assign adc_hi_byte    = st != S_RD_LO;
  assign adc_right_just = rj_q;

  logic [IV_W-1:0]  sc_gap;
  logic [CNT_W-1:0] pu_age;
  logic [CNT_W-1:0] oe_gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_gap <= IV_W'(MIN_INTERVAL_CYC);
      pu_age <= '0;
      oe_gap <= CNT_W'(RECOVER_CYC);
    end else begin
      if (!adc_sc_n) sc_gap <= IV_W'(1);
      else if (sc_gap != IV_W'(MIN_INTERVAL_CYC)) sc_gap <= sc_gap + 1'b1;
      if (pu_age != CNT_W'(POWERUP_CYC)) pu_age <= pu_age + 1'b1;
      if (!adc_oe_n) oe_gap <= '0;
      else if (oe_gap != CNT_W'(RECOVER_CYC)) oe_gap <= oe_gap + 1'b1;
    end
  end

  AST_POWERUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !adc_sc_n |-> pu_age >= CNT_W'(POWERUP_CYC)); // R1
  AST_SC_SPACING: assert property (@(posedge clk) disable iff (!rst_n) $fell(adc_sc_n) |-> sc_gap >= IV_W'(MIN_INTERVAL_CYC)); // R2
  AST_SC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) !adc_sc_n |=> adc_sc_n); // R2
  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) !adc_oe_n |-> !adc_cs_n); // R11
  AST_SC_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !adc_sc_n |-> adc_cs_n && adc_oe_n); // R11
  AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid); // R8
  AST_TIMEOUT_ONE: assert property (@(posedge clk) disable iff (!rst_n) eoc_timeout |-> !res_valid ##1 !eoc_timeout); // R10
  AST_RECOVER_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(adc_sc_n) |-> oe_gap >= CNT_W'(RECOVER_CYC)); // R9
endmodule

// File: tb/adc_seq_test.sv
module adc_seq_test;
  localparam int PU = 500, MINI = 250, SETUP = 3, RD = 4, REC = 5, TO = 1000;

  logic clk = 1'b0, rst_n = 1'b0, conv_req = 1'b0, wide_mode = 1'b1, right_just = 1'b0;
  logic eoc;
  logic [11:0] bus;
  logic sc_n, cs_n, oe_n, hi_byte, rj_pin, res_valid, eoc_timeout;
  logic [11:0] res_data;

  always #10 clk = ~clk;

  adc_seq #(.DATA_W(12), .BYTE_W(8), .POWERUP_CYC(PU), .MIN_INTERVAL_CYC(MINI),
            .CS_SETUP_CYC(SETUP), .READ_CYC(RD), .RECOVER_CYC(REC), .EOC_TIMEOUT_CYC(TO)) uut (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .wide_mode(wide_mode), .right_just(right_just),
    .adc_eoc(eoc), .adc_data(bus), .adc_sc_n(sc_n), .adc_cs_n(cs_n), .adc_oe_n(oe_n),
    .adc_hi_byte(hi_byte), .adc_right_just(rj_pin), .res_valid(res_valid), .res_data(res_data),
    .eoc_timeout(eoc_timeout));

  function automatic logic [7:0] byte_img(input logic [11:0] v, input logic rj, input logic hi);
    if (rj) return hi ? {4'h0, v[11:8]} : v[7:0];
    return hi ? v[11:4] : {v[3:0], 4'h0};
  endfunction

  // converter stub
  logic [11:0] stub_val, conv_val;
  logic stub_wide;
  int stub_lat, lat_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin eoc <= 1'b1; lat_cnt <= 0; conv_val <= 12'h0; end
    else if (!sc_n) begin eoc <= 1'b0; lat_cnt <= stub_lat; end
    else if (lat_cnt == 1) begin eoc <= 1'b1; conv_val <= stub_val; lat_cnt <= 0; end
    else if (lat_cnt > 1) lat_cnt <= lat_cnt - 1;
  end
  assign bus = (!cs_n && !oe_n) ? (stub_wide ? conv_val : {byte_img(conv_val, rj_pin, hi_byte), 4'h5})
                                : 12'hC3C;

  // timing monitor
  int cyc = 0, rel_cyc = -1, last_sc = -1, last_oe_rise = -1, cs_fall = 0;
  int sc_cnt = 0, val_cnt = 0, win_cnt = 0, mon_checks = 0, mon_errs = 0;
  logic [3:0] hi_seq = '0;
  logic rl_seen = 1'b0;
  logic p_sc = 1'b1, p_cs = 1'b1, p_oe = 1'b1, p_val = 1'b0, p_to = 1'b0, p_rst = 1'b0;

  task automatic mon_chk(input bit ok, input string req, input int act, input int exp);
    mon_checks++;
    if (!ok) begin mon_errs++; $display("FAIL %s: actual %0d expected %0d", req, act, exp); end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !p_rst) rel_cyc = cyc - 1;
    if (rst_n) begin
      if (!sc_n && p_sc) begin
        sc_cnt++;
        if (last_sc < 0) mon_chk(cyc - rel_cyc >= PU, "R1 powerup hold", cyc - rel_cyc, PU);
        else mon_chk(cyc - last_sc >= MINI, "R2 start spacing", cyc - last_sc, MINI);
        if (last_oe_rise >= 0) mon_chk(cyc - last_oe_rise >= REC, "R9 recovery", cyc - last_oe_rise, REC);
        last_sc = cyc;
      end
      if (!sc_n && !p_sc) mon_chk(0, "R2 pulse width", 2, 1);
      if (!cs_n && p_cs) cs_fall = cyc;
      if (!oe_n && p_oe) begin
        mon_chk(cyc - cs_fall >= SETUP, "R4 cs setup", cyc - cs_fall, SETUP);
        mon_chk(eoc == 1'b1, "R4 eoc before read", int'(eoc), 1);
      end
      if (!oe_n) begin
        if (p_oe || p_hi_d != hi_byte) begin win_cnt++; hi_seq = {hi_seq[2:0], hi_byte}; rl_seen = rj_pin; end
      end
      if (oe_n && !p_oe) last_oe_rise = cyc;
      if (!oe_n && cs_n) mon_chk(0, "R11 oe without cs", 1, 0);
      if (!sc_n && (!cs_n || !oe_n)) mon_chk(0, "R11 bus during start", 1, 0);
      if (res_valid) val_cnt++;
      if (res_valid && p_val) mon_chk(0, "R8 valid width", 2, 1);
      if (eoc_timeout && p_to) mon_chk(0, "R10 timeout width", 2, 1);
    end
    p_sc = sc_n; p_cs = cs_n; p_oe = oe_n; p_val = res_valid; p_to = eoc_timeout; p_rst = rst_n;
    p_hi_d = hi_byte;
  end
  logic p_hi_d = 1'b1;

  int checks = 0, errs = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errs++; $display("FAIL %s: actual %0h expected %0h", req, act, exp); end
  endtask

  task automatic run_conv(input logic [11:0] v, input logic w, input logic rj, input int lat, input bit flip);
    int sc0, v0, w0;
    bit got_v, got_to;
    logic [11:0] d;
    sc0 = sc_cnt; v0 = val_cnt; w0 = win_cnt;
    stub_val = v; stub_wide = w; stub_lat = lat; wide_mode = w; right_just = rj;
    @(negedge clk); conv_req = 1'b1;
    @(negedge clk); conv_req = 1'b0;
    got_v = 0; got_to = 0; d = '0;
    for (int i = 0; i < 3000 && !got_v && !got_to; i++) begin
      @(negedge clk);
      if (flip && !cs_n) begin wide_mode = !w; right_just = !rj; end
      if (res_valid) begin got_v = 1; d = res_data; end
      if (eoc_timeout) got_to = 1;
    end
    repeat (3) @(negedge clk);
    if (lat == 0) begin
      chk(got_to && !got_v, "R10 timeout raised, no result", {got_to, got_v}, 2);
      chk(win_cnt == w0, "R10 no read window", win_cnt - w0, 0);
    end else begin
      chk(got_v, "R8 result delivered", got_v, 1);
      chk(val_cnt - v0 == 1, "R8 single valid", val_cnt - v0, 1);
      chk(sc_cnt - sc0 == 1, "R3 one start per request", sc_cnt - sc0, 1);
      chk(d == v, w ? "R5 wide result" : "R6 narrow result", d, v);
      if (w) chk(win_cnt - w0 == 1 && hi_seq[0], "R5 one window", win_cnt - w0, 1);
      else begin
        chk(win_cnt - w0 == 2 && hi_seq[1:0] == 2'b10, "R6 high then low", {win_cnt - w0, hi_seq[1:0]}, 'h22);
        chk(rl_seen == rj, "R7 latched justification", rl_seen, rj);
      end
    end
    wide_mode = 1'b1; right_just = 1'b0;
  endtask

  initial begin
    int sc0, v0;
    void'($urandom(32'd4242));
    stub_val = 12'h0; stub_wide = 1'b1; stub_lat = 5;
    repeat (4) @(negedge clk);
    chk(sc_n && cs_n && oe_n && !res_valid && !eoc_timeout, "R1 reset outputs",
        {sc_n, cs_n, oe_n, res_valid, eoc_timeout}, 'h1C);
    rst_n = 1'b1;
    // request during power-up: held (R3), served after the wait (R1)
    run_conv(12'hA5C, 1'b1, 1'b0, 7, 0);
    run_conv(12'hFFF, 1'b1, 1'b0, 1, 0);
    run_conv(12'h000, 1'b1, 1'b0, 30, 0);
    run_conv(12'h9E1, 1'b0, 1'b0, 12, 0);
    run_conv(12'h9E1, 1'b0, 1'b1, 12, 0);
    run_conv(12'hF0F, 1'b0, 1'b1, 3, 0);
    run_conv(12'h0F0, 1'b0, 1'b0, 3, 0);
    // R7: mode inputs flipped during the read
    run_conv(12'h3B6, 1'b0, 1'b1, 9, 1);
    run_conv(12'h7C2, 1'b1, 1'b0, 9, 1);
    // R10: silent converter, then recovery
    run_conv(12'h123, 1'b1, 1'b0, 0, 0);
    run_conv(12'h456, 1'b0, 1'b0, 4, 0);
    // R3: two requests inside one spacing window merge into one conversion
    sc0 = sc_cnt; v0 = val_cnt;
    stub_val = 12'h8D4; stub_wide = 1'b1; stub_lat = 6;
    @(negedge clk); conv_req = 1'b1; @(negedge clk); conv_req = 1'b0;
    repeat (10) @(negedge clk);
    conv_req = 1'b1; @(negedge clk); conv_req = 1'b0;
    repeat (700) @(negedge clk);
    chk(sc_cnt - sc0 == 1, "R3 merged requests", sc_cnt - sc0, 1);
    chk(val_cnt - v0 == 1, "R3 merged results", val_cnt - v0, 1);
    chk(res_data == 12'h8D4, "R3 held request result", res_data, 12'h8D4);
    for (int k = 0; k < 25; k++) begin
      logic [11:0] rv;
      rv = 12'($urandom % 4096);
      run_conv(rv, 1'($urandom % 2), 1'($urandom % 2), 1 + int'($urandom % 60), 1'($urandom % 2));
    end
    $display("Result: errors=%0d of %0d checks", errs + mon_errs, checks + mon_checks);
    $finish;
  end

  initial begin
    #4000000;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errs + mon_errs + 1, checks + mon_checks + 1);
    $finish;
  end
endmodule